// File: doc/BRIEF.md
# Line Uniformity Statistics Engine

This block measures how even one full scan line of an image sensor is. The line arrives as eight parallel taps. Each tap carries a consecutive run of pixels, and all eight taps move together on a shared valid strobe. The block puts the taps back in line order. While the pixels stream in, it keeps the running sum, the extremes and the steepest relative step between neighbouring pixels. The steps where one tap meets the next are handled as well, even though those two pixels arrive far apart in time.

When the last beat of the line has been taken, a short merge pass folds the tap-local step candidates and the seven tap-junction pairs into one best ratio. A single shared restoring divider then works out the line average and the ratio figures in sequence. A line taken in dark mode reports the raw pixel spread instead of the ratios. A one-cycle done pulse marks the moment when all result outputs hold the figures for the line just taken. Ratios are unsigned fixed point in percent with `FRAC_W` fraction bits, so the value is floor(ratio × 100 × 2^FRAC_W). With the defaults the scale factor is 1600.

Top module: `line_uniformity`

## Requirements
- R1: A line starts on a beat where `line_start` and `pix_valid` are both high while the block is idle. It takes exactly `TAP_LEN` valid beats. On beat j, tap t (bits `[t*PIX_W +: PIX_W]` of `pix_bus`) carries line pixel t*`TAP_LEN`+j. Valid beats in idle without `line_start` are ignored.
- R2: `avg_o` equals floor(sum of all `NTAPS*TAP_LEN` pixels / (`NTAPS*TAP_LEN`)).
- R3: `max_o` and `min_o` equal the largest and smallest pixel of the line.
- R4: In bright mode, pos = max−avg and neg = avg−min. `bright_neg_o` is 1 only when neg > pos (a tie reports positive, 0). `bright_nu_o` = floor(larger × 1600 / avg), or 0 when avg is 0.
- R5: In bright mode, `total_nu_o` = floor((max−min) × 1600 / avg), or 0 when avg is 0.
- R6: In bright mode, `adj_nu_o` is the maximum over line positions n of floor(|p(n)−p(n+1)| × 1600 / p(n)).
- R7: The adjacency search of R6 includes the pair formed by the last pixel of tap k and the first pixel of tap k+1, for every tap junction.
- R8: A pair whose leading pixel p(n) is zero is skipped. If no pair qualifies, `adj_nu_o` is 0.
- R9: `dark_sel` is sampled on the line's first beat. In dark mode, `dark_spread_o` = max−min and `bright_nu_o`, `bright_neg_o`, `total_nu_o` and `adj_nu_o` are 0. In bright mode, `dark_spread_o` is 0.
- R10: `done` is high for exactly one cycle per accepted line. All result outputs are valid in that cycle.
- R11: From the first beat of a line until its `done`, further `line_start` pulses do not open a new line, and beats after the line's last beat are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Marks the first beat of a line |
| pix_valid | input | 1 | All taps carry a pixel this cycle |
| pix_bus | input | NTAPS*PIX_W | Packed tap pixels, tap 0 in the low bits |
| dark_sel | input | 1 | 1 selects dark-spread mode for this line |
| done | output | 1 | One-cycle pulse, results valid |
| avg_o | output | PIX_W | Line average |
| max_o | output | PIX_W | Line maximum |
| min_o | output | PIX_W | Line minimum |
| bright_nu_o | output | PIX_W+clog2(100·2^FRAC_W) | Larger bright deviation ratio |
| bright_neg_o | output | 1 | 1 when the negative deviation was chosen |
| total_nu_o | output | PIX_W+clog2(100·2^FRAC_W) | Total deviation ratio |
| adj_nu_o | output | PIX_W+clog2(100·2^FRAC_W) | Steepest neighbour ratio |
| dark_spread_o | output | PIX_W | Max minus min in dark mode |

## Verification
Lines of full-range random pixels exercise the average, the extremes and all three ratios at once, and they separate errors in the sum from errors in the divider. Each of the following flat lines has one planted defect:
- A flat line with a single deep dip forces the negative polarity.
- A flat line with a raised first pixel in one tap makes a junction pair the steepest step, so a design that drops cross-tap pairs gives a different figure.
- A line of zeros and full-scale values checks that zero-led pairs are skipped.
- An all-zero line checks the zero-average guards.

Dark lines of small values check the spread path and the cleared ratios. A line driven with stray start pulses and dark-select toggles during and after its collection checks that only the first start counts and that no second done follows.

// File: rtl/lut_pkg.sv
package lut_pkg;

    localparam int unsigned DEF_TAPS    = 8;
    localparam int unsigned DEF_TAP_LEN = 960;
    localparam int unsigned DEF_PIX_W   = 12;
    localparam int unsigned DEF_FRAC_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLL,
        ST_MERGE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } ctl_state_e;

    typedef enum logic [1:0] {
        JOB_AVG,
        JOB_DEV,
        JOB_TOT,
        JOB_ADJ
    } div_job_e;

endpackage

// File: rtl/lut_tap_track.sv
// Per-tap tracker: holds the first and most recent pixel and the
// steepest relative step inside the tap as a numerator/denominator pair.
module lut_tap_track #(
    parameter int unsigned PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat,
    input  logic             first_beat,
    input  logic [PIX_W-1:0] pix,
    output logic [PIX_W-1:0] first_o,
    output logic [PIX_W-1:0] last_o,
    output logic [PIX_W-1:0] nbest_o,
    output logic [PIX_W-1:0] dbest_o
);
    localparam int unsigned PW2 = 2 * PIX_W;

    logic [PIX_W-1:0] diff;
    logic [PW2-1:0]   lhs;
    logic [PW2-1:0]   rhs;
    logic             win;

    always_comb begin
        diff = (last_o > pix) ? (last_o - pix) : (pix - last_o);
        lhs  = PW2'(diff) * PW2'(dbest_o);
        rhs  = PW2'(nbest_o) * PW2'(last_o);
        win  = (last_o != '0) && (lhs > rhs);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first_o <= '0;
            last_o  <= '0;
            nbest_o <= '0;
            dbest_o <= PIX_W'(1);
        end else if (beat) begin
            last_o <= pix;
            if (first_beat) begin
                first_o <= pix;
                nbest_o <= '0;
                dbest_o <= PIX_W'(1);
            end else if (win) begin
                nbest_o <= diff;
                dbest_o <= last_o;
            end
        end
    end
endmodule

// File: rtl/lut_line_stats.sv
// Running sum, maximum and minimum over all taps of a beat.
module lut_line_stats #(
    parameter int unsigned NTAPS = 8,
    parameter int unsigned PIX_W = 12,
    parameter int unsigned SUM_W = 25
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   beat,
    input  logic                   first_beat,
    input  logic [NTAPS*PIX_W-1:0] pix_bus,
    output logic [SUM_W-1:0]       sum_o,
    output logic [PIX_W-1:0]       max_o,
    output logic [PIX_W-1:0]       min_o
);
    logic [SUM_W-1:0] b_sum;
    logic [PIX_W-1:0] b_max;
    logic [PIX_W-1:0] b_min;

    always_comb begin
        b_sum = '0;
        b_max = pix_bus[PIX_W-1:0];
        b_min = pix_bus[PIX_W-1:0];
        for (int i = 0; i < int'(NTAPS); i++) begin
            b_sum = b_sum + SUM_W'(pix_bus[i*PIX_W +: PIX_W]);
            if (pix_bus[i*PIX_W +: PIX_W] > b_max) b_max = pix_bus[i*PIX_W +: PIX_W];
            if (pix_bus[i*PIX_W +: PIX_W] < b_min) b_min = pix_bus[i*PIX_W +: PIX_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_o <= '0;
            max_o <= '0;
            min_o <= '0;
        end else if (beat) begin
            if (first_beat) begin
                sum_o <= b_sum;
                max_o <= b_max;
                min_o <= b_min;
            end else begin
                sum_o <= sum_o + b_sum;
                if (b_max > max_o) max_o <= b_max;
                if (b_min < min_o) min_o <= b_min;
            end
        end
    end
endmodule

// File: rtl/lut_seq_div.sv
// Restoring divider, one quotient bit per cycle, NW cycles per divide.
module lut_seq_div #(
    parameter int unsigned NW = 25,
    parameter int unsigned DW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [NW-1:0] quo
);
    localparam int unsigned CW = $clog2(NW + 1);

    logic [DW-1:0] rem;
    logic [NW-1:0] acc;
    logic [DW-1:0] den_q;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [DW:0]   trial;
    logic [DW:0]   sub;
    logic          ge;

    always_comb begin
        trial = {rem, acc[NW-1]};
        sub   = trial - {1'b0, den_q};
        ge    = trial >= {1'b0, den_q};
    end

    assign quo = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            acc   <= '0;
            den_q <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem   <= '0;
                acc   <= num;
                den_q <= den;
                cnt   <= CW'(NW);
                busy  <= 1'b1;
            end else if (busy) begin
                rem <= ge ? sub[DW-1:0] : trial[DW-1:0];
                acc <= {acc[NW-2:0], ge};
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/line_uniformity.sv
module line_uniformity
    import lut_pkg::*;
#(
    parameter int unsigned NTAPS   = DEF_TAPS,
    parameter int unsigned TAP_LEN = DEF_TAP_LEN,
    parameter int unsigned PIX_W   = DEF_PIX_W,
    parameter int unsigned FRAC_W  = DEF_FRAC_W,
    localparam int unsigned RW     = PIX_W + $clog2(100 << FRAC_W)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   line_start,
    input  logic                   pix_valid,
    input  logic [NTAPS*PIX_W-1:0] pix_bus,
    input  logic                   dark_sel,
    output logic                   done,
    output logic [PIX_W-1:0]       avg_o,
    output logic [PIX_W-1:0]       max_o,
    output logic [PIX_W-1:0]       min_o,
    output logic [RW-1:0]          bright_nu_o,
    output logic                   bright_neg_o,
    output logic [RW-1:0]          total_nu_o,
    output logic [RW-1:0]          adj_nu_o,
    output logic [PIX_W-1:0]       dark_spread_o
);
    localparam int unsigned NPIX  = NTAPS * TAP_LEN;
    localparam int unsigned SCALE = 100 << FRAC_W;
    localparam int unsigned SUM_W = PIX_W + $clog2(NPIX);
    localparam int unsigned NW    = (SUM_W > RW) ? SUM_W : RW;
    localparam int unsigned NPW   = $clog2(NPIX + 1);
    localparam int unsigned DW    = (PIX_W > NPW) ? PIX_W : NPW;
    localparam int unsigned CNT_W = $clog2(TAP_LEN + 1);
    localparam int unsigned MCNT  = 2 * NTAPS - 1;
    localparam int unsigned MW    = $clog2(MCNT + 1);
    localparam int unsigned PW2   = 2 * PIX_W;

    ctl_state_e       state;
    div_job_e         job;
    logic [CNT_W-1:0] beat_cnt;
    logic             mode_q;
    logic [MW-1:0]    m_idx;
    logic [PIX_W-1:0] best_n;
    logic [PIX_W-1:0] best_d;

    logic accept;
    logic beat;
    logic last_beat;

    assign accept    = (state == ST_IDLE) && pix_valid && line_start;
    assign beat      = accept || ((state == ST_COLL) && pix_valid);
    assign last_beat = (accept && (TAP_LEN == 1)) ||
                       ((state == ST_COLL) && pix_valid && (beat_cnt == CNT_W'(TAP_LEN - 1)));
    assign done      = (state == ST_DONE);

    // Line statistics
    logic [SUM_W-1:0] sum_w;

    lut_line_stats #(.NTAPS(NTAPS), .PIX_W(PIX_W), .SUM_W(SUM_W)) u_stats (
        .clk        (clk),
        .rst        (rst),
        .beat       (beat),
        .first_beat (accept),
        .pix_bus    (pix_bus),
        .sum_o      (sum_w),
        .max_o      (max_o),
        .min_o      (min_o)
    );

    // One neighbour tracker per tap
    logic [PIX_W-1:0] t_first [NTAPS];
    logic [PIX_W-1:0] t_last  [NTAPS];
    logic [PIX_W-1:0] t_n     [NTAPS];
    logic [PIX_W-1:0] t_d     [NTAPS];

    for (genvar g = 0; g < int'(NTAPS); g++) begin : g_tap
        lut_tap_track #(.PIX_W(PIX_W)) u_trk (
            .clk        (clk),
            .rst        (rst),
            .beat       (beat),
            .first_beat (accept),
            .pix        (pix_bus[g*PIX_W +: PIX_W]),
            .first_o    (t_first[g]),
            .last_o     (t_last[g]),
            .nbest_o    (t_n[g]),
            .dbest_o    (t_d[g])
        );
    end

    // Merge candidates: tap-local bests first, then the tap junctions
    logic [PIX_W-1:0] c_n;
    logic [PIX_W-1:0] c_d;
    logic             c_win;

    always_comb begin
        c_n = '0;
        c_d = PIX_W'(1);
        for (int i = 0; i < int'(NTAPS); i++) begin
            if (m_idx == MW'(i)) begin
                c_n = t_n[i];
                c_d = t_d[i];
            end
        end
        for (int k = 0; k + 1 < int'(NTAPS); k++) begin
            if ((m_idx == MW'(int'(NTAPS) + k)) && (t_last[k] != '0)) begin
                c_n = (t_last[k] > t_first[k+1]) ? (t_last[k] - t_first[k+1])
                                                 : (t_first[k+1] - t_last[k]);
                c_d = t_last[k];
            end
        end
        c_win = (PW2'(c_n) * PW2'(best_d)) > (PW2'(best_n) * PW2'(c_d));
    end

    // Divide job operands
    logic [PIX_W-1:0] pos_dev;
    logic [PIX_W-1:0] neg_dev;
    logic [NW-1:0]    d_num;
    logic [DW-1:0]    d_den;
    logic             den_zero;
    logic             d_start;
    logic             d_done;
    logic [NW-1:0]    d_quo;
    logic             job_end;
    logic [NW-1:0]    res_val;
    logic             last_job;

    always_comb begin
        pos_dev = max_o - avg_o;
        neg_dev = avg_o - min_o;
        unique case (job)
            JOB_AVG: begin
                d_num = NW'(sum_w);
                d_den = DW'(NPIX);
            end
            JOB_DEV: begin
                d_num = NW'((neg_dev > pos_dev) ? neg_dev : pos_dev) * NW'(SCALE);
                d_den = DW'(avg_o);
            end
            JOB_TOT: begin
                d_num = NW'(max_o - min_o) * NW'(SCALE);
                d_den = DW'(avg_o);
            end
            default: begin
                d_num = NW'(best_n) * NW'(SCALE);
                d_den = DW'(best_d);
            end
        endcase
        den_zero = (d_den == '0);
        d_start  = (state == ST_ISSUE) && !den_zero;
        job_end  = ((state == ST_ISSUE) && den_zero) || ((state == ST_WAIT) && d_done);
        res_val  = (state == ST_WAIT) ? d_quo : '0;
        last_job = (job == JOB_ADJ) || ((job == JOB_AVG) && mode_q);
    end

    lut_seq_div #(.NW(NW), .DW(DW)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (d_start),
        .num   (d_num),
        .den   (d_den),
        .done  (d_done),
        .quo   (d_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            job           <= JOB_AVG;
            beat_cnt      <= '0;
            mode_q        <= 1'b0;
            m_idx         <= '0;
            best_n        <= '0;
            best_d        <= PIX_W'(1);
            avg_o         <= '0;
            bright_nu_o   <= '0;
            bright_neg_o  <= 1'b0;
            total_nu_o    <= '0;
            adj_nu_o      <= '0;
            dark_spread_o <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        beat_cnt      <= CNT_W'(1);
                        mode_q        <= dark_sel;
                        bright_nu_o   <= '0;
                        bright_neg_o  <= 1'b0;
                        total_nu_o    <= '0;
                        adj_nu_o      <= '0;
                        dark_spread_o <= '0;
                        m_idx         <= '0;
                        best_n        <= '0;
                        best_d        <= PIX_W'(1);
                        state         <= last_beat ? ST_MERGE : ST_COLL;
                    end
                end
                ST_COLL: begin
                    if (pix_valid) begin
                        beat_cnt <= beat_cnt + CNT_W'(1);
                        if (last_beat) state <= ST_MERGE;
                    end
                end
                ST_MERGE: begin
                    if (c_win) begin
                        best_n <= c_n;
                        best_d <= c_d;
                    end
                    m_idx <= m_idx + MW'(1);
                    if (m_idx == MW'(MCNT - 1)) begin
                        job   <= JOB_AVG;
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (job == JOB_DEV) bright_neg_o <= neg_dev > pos_dev;
                    if (!den_zero) state <= ST_WAIT;
                end
                ST_WAIT: ;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase

            if (job_end) begin
                unique case (job)
                    JOB_AVG: begin
                        avg_o <= res_val[PIX_W-1:0];
                        if (mode_q) dark_spread_o <= max_o - min_o;
                    end
                    JOB_DEV: bright_nu_o <= res_val[RW-1:0];
                    JOB_TOT: total_nu_o  <= res_val[RW-1:0];
                    default: adj_nu_o    <= res_val[RW-1:0];
                endcase
                if (last_job) begin
                    state <= ST_DONE;
                end else begin
                    job   <= div_job_e'(job + 2'd1);
                    state <= ST_ISSUE;
                end
            end
        end
    end
endmodule

// File: rtl/line_uniformity_chk.sv
module line_uniformity_chk #(
    parameter int unsigned PIX_W = 12,
    parameter int unsigned RW    = 23
) (
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic             mode_q,
    input logic [PIX_W-1:0] avg_o,
    input logic [PIX_W-1:0] max_o,
    input logic [PIX_W-1:0] min_o,
    input logic [RW-1:0]    bright_nu_o,
    input logic             bright_neg_o,
    input logic [RW-1:0]    total_nu_o,
    input logic [RW-1:0]    adj_nu_o,
    input logic [PIX_W-1:0] dark_spread_o
);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_min_le_max: assert property (@(posedge clk) disable iff (rst)
        done |-> (min_o <= max_o));

    a_r2_avg_in_range: assert property (@(posedge clk) disable iff (rst)
        done |-> ((avg_o >= min_o) && (avg_o <= max_o)));

    a_r9_dark_no_ratio: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q) |-> ((bright_nu_o == '0) && (total_nu_o == '0) &&
                              (adj_nu_o == '0) && !bright_neg_o));

    a_r9_bright_no_spread: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q) |-> (dark_spread_o == '0));

    a_r5_total_ge_bright: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q) |-> (total_nu_o >= bright_nu_o));
endmodule

bind line_uniformity line_uniformity_chk #(.PIX_W(PIX_W), .RW(RW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .done          (done),
    .mode_q        (mode_q),
    .avg_o         (avg_o),
    .max_o         (max_o),
    .min_o         (min_o),
    .bright_nu_o   (bright_nu_o),
    .bright_neg_o  (bright_neg_o),
    .total_nu_o    (total_nu_o),
    .adj_nu_o      (adj_nu_o),
    .dark_spread_o (dark_spread_o)
);

// File: tb/sim_line_uniformity.sv
module sim_line_uniformity;
    localparam int NT = 8;
    localparam int TL = 960;
    localparam int PW = 12;
    localparam int NP = NT * TL;
    localparam int RW = 23;
    localparam longint SCL = 1600;

    logic clk = 1'b0;
    logic rst;
    logic line_start, pix_valid, dark_sel;
    logic [NT*PW-1:0] pix_bus;
    logic done, bright_neg_o;
    logic [PW-1:0] avg_o, max_o, min_o, dark_spread_o;
    logic [RW-1:0] bright_nu_o, total_nu_o, adj_nu_o;

    always #2 clk = ~clk;

    line_uniformity u0 (
        .clk(clk), .rst(rst), .line_start(line_start), .pix_valid(pix_valid),
        .pix_bus(pix_bus), .dark_sel(dark_sel), .done(done), .avg_o(avg_o),
        .max_o(max_o), .min_o(min_o), .bright_nu_o(bright_nu_o),
        .bright_neg_o(bright_neg_o), .total_nu_o(total_nu_o),
        .adj_nu_o(adj_nu_o), .dark_spread_o(dark_spread_o)
    );

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit finished = 0;
    int unsigned line_px [NP];
    longint e_avg, e_max, e_min, e_bnu, e_pol, e_tnu, e_anu, e_spr;

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic calc_expected(bit dark);
        longint sum = 0;
        longint pos, neg, r;
        e_max = 0;
        e_min = 1 << PW;
        for (int i = 0; i < NP; i++) begin
            sum += line_px[i];
            if (line_px[i] > e_max) e_max = line_px[i];
            if (line_px[i] < e_min) e_min = line_px[i];
        end
        e_avg = sum / NP;
        pos = e_max - e_avg;
        neg = e_avg - e_min;
        e_anu = 0;
        for (int i = 0; i + 1 < NP; i++) begin
            if (line_px[i] != 0) begin
                r = longint'(line_px[i] > line_px[i+1] ? line_px[i] - line_px[i+1]
                                                       : line_px[i+1] - line_px[i]);
                r = r * SCL / line_px[i];
                if (r > e_anu) e_anu = r;
            end
        end
        if (dark) begin
            e_bnu = 0; e_pol = 0; e_tnu = 0; e_anu = 0;
            e_spr = e_max - e_min;
        end else begin
            e_pol = (neg > pos) ? 1 : 0;
            e_bnu = (e_avg == 0) ? 0 : ((neg > pos) ? neg : pos) * SCL / e_avg;
            e_tnu = (e_avg == 0) ? 0 : (e_max - e_min) * SCL / e_avg;
            e_spr = 0;
        end
    endtask

    task automatic run_line(bit dark, bit garble, string adj_tag);
        int cyc = 0;
        int early = 0;
        // R1: valid beats in idle without a start are ignored
        repeat (3) begin
            @(negedge clk);
            line_start = 1'b0; pix_valid = 1'b1; pix_bus = {3{$urandom}};
        end
        for (int j = 0; j < TL; j++) begin
            @(negedge clk);
            if (done) early++;
            line_start = (j == 0) || (garble && ($urandom_range(0, 15) == 0));
            pix_valid  = 1'b1;
            dark_sel   = (j == 0) ? dark : (garble ? ~dark : dark);
            for (int t = 0; t < NT; t++) pix_bus[t*PW +: PW] = PW'(line_px[t*TL + j]);
        end
        forever begin
            @(negedge clk);
            if (done || cyc > 4000) break;
            cyc++;
            if (garble) begin
                line_start = 1'b1; pix_valid = 1'b1;
                pix_bus = {3{$urandom}}; dark_sel = $urandom_range(0, 1) == 1;
            end else begin
                line_start = 1'b0; pix_valid = 1'b0;
            end
        end
        line_start = 1'b0; pix_valid = 1'b0;
        check("R10 done reached", longint'(done), 1);
        check("R11 no done while collecting", early, 0);
        calc_expected(dark);
        check("R2 average", avg_o, e_avg);
        check("R3 maximum", max_o, e_max);
        check("R3 minimum", min_o, e_min);
        check(dark ? "R9 bright ratio cleared" : "R4 bright ratio", bright_nu_o, e_bnu);
        check(dark ? "R9 polarity cleared" : "R4 polarity", longint'(bright_neg_o), e_pol);
        check(dark ? "R9 total cleared" : "R5 total ratio", total_nu_o, e_tnu);
        check(dark ? "R9 adjacent cleared" : adj_tag, adj_nu_o, e_anu);
        check("R9 dark spread", dark_spread_o, e_spr);
        @(negedge clk);
        check("R10 done one cycle", longint'(done), 0);
        if (garble) begin
            int seen = 0;
            repeat (300) begin
                @(negedge clk);
                if (done) seen++;
            end
            check("R11 stray start ignored", seen, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R10 watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20431));
        rst = 1'b1; line_start = 1'b0; pix_valid = 1'b0; dark_sel = 1'b0; pix_bus = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset done low", longint'(done), 0);
        check("R3 reset max", max_o, 0);
        check("R2 reset avg", avg_o, 0);

        // random full range, bright
        for (int i = 0; i < NP; i++) line_px[i] = $urandom_range(0, 4095);
        run_line(1'b0, 1'b0, "R1/R6 adjacent");

        // flat with a deep dip: negative polarity
        for (int i = 0; i < NP; i++) line_px[i] = 1000;
        line_px[3001] = 100;
        run_line(1'b0, 1'b0, "R6 adjacent dip");

        // raised first pixel of tap 3: junction pair is steepest
        for (int i = 0; i < NP; i++) line_px[i] = 1000;
        line_px[3*TL] = 2000;
        run_line(1'b0, 1'b0, "R7 junction adjacent");

        // zero-led pairs skipped
        for (int i = 0; i < NP; i++) line_px[i] = ($urandom_range(0, 1) == 1) ? 4095 : 0;
        run_line(1'b0, 1'b0, "R8 zero leader");

        // all zero line
        for (int i = 0; i < NP; i++) line_px[i] = 0;
        run_line(1'b0, 1'b0, "R8 all zero");

        // dark line of small values
        for (int i = 0; i < NP; i++) line_px[i] = $urandom_range(0, 63);
        run_line(1'b1, 1'b0, "R9 adjacent");

        // stray starts and mode toggles during and after collection
        for (int i = 0; i < NP; i++) line_px[i] = $urandom_range(800, 1200);
        run_line(1'b0, 1'b1, "R6 adjacent garbled");

        // mixed random lines
        for (int r = 0; r < 3; r++) begin
            int lo = $urandom_range(0, 2000);
            for (int i = 0; i < NP; i++) line_px[i] = $urandom_range(lo, lo + 2000);
            run_line(r == 1, 1'b0, "R6 adjacent mixed");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule